// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block turns one operand specifier into an operand location and fetches the operand. It sits between instruction decode and the execute stage of a small 16-bit processor. The specifier holds a 3-bit mode and a 3-bit register number. It is taken from one of the two specifier fields of the instruction word, either the source field or the destination field. The block contains the eight-entry register file, and entry 7 acts as the program counter. It performs the pointer adjustments that each mode asks for. It reads extension words at the program counter, and it follows pointers through a word-wide read port with a request/ready handshake.

When it finishes, the block pulses `done` for one cycle. At that point it presents the operand value, the effective address, and a flag that tells a register operand from a memory operand. No new mode codes are needed for immediate, absolute and PC-relative operands: these come from using the program counter in the auto-increment and indexed modes. Only word accesses exist, so every pointer step is 2 and every address is even. A separate write/read port on the register file lets the surrounding pipeline load and observe registers while the sequencer is idle.

Top module: `amseq_top`

## Requirements
- R1: With `src_sel`=1 the specifier is `spec_pair[11:6]`; with `src_sel`=0 it is `spec_pair[5:0]`. Within a specifier, bits 5:3 are the mode and bits 2:0 are the register number.
- R2: Mode 0 produces `done` in the cycle after `start`. It sets `operand` to the register contents, sets `eff_addr` to the register number zero-extended, and sets `is_reg`=1. It makes no memory request.
- R3: Mode 1 makes one memory read at the register contents. `eff_addr` is that address, `operand` is the word read, `is_reg`=0, and the register is left unchanged.
- R4: Mode 2 reads at the register contents and then leaves the register 2 higher. With register 7 this yields the immediate word at the program counter.
- R5: Mode 3 reads a pointer at the register contents and leaves the register 2 higher. `eff_addr` is the pointer and `operand` is the word at the pointer, so there are two reads. With register 7 this is an absolute address.
- R6: Mode 4 first lowers the register by 2. It then reads at the new register value, which is also `eff_addr`.
- R7: Mode 5 first lowers the register by 2. It then reads a pointer at the new value, and reads the operand at that pointer.
- R8: Mode 6 reads the extension word X at the program counter and raises the program counter by 2. `eff_addr` is the register plus X, modulo 2^16. With register 7 the base is the program counter after the step, that is PC+2. There are two reads.
- R9: Mode 7 works as mode 6 and then reads a pointer at the indexed address. `eff_addr` is that pointer, and there are three reads.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_rdy` is sampled high. Read data is taken in the cycle in which `mem_rdy` is high.
- R11: `done` lasts exactly one cycle, and `mem_req` is low while `done` is high. A `start` given while an access sequence is in progress is ignored and does not alter the result.
- R12: After reset, `done`, `is_reg` and `mem_req` are 0.
- R13: `rf_we` writes `rf_wdata` into register `rf_waddr` at the clock edge. `rf_rdata` shows register `rf_raddr` at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin evaluating a specifier (taken only when idle) |
| spec_pair | input | 12 | Source and destination specifier fields of the instruction word |
| src_sel | input | 1 | 1 selects the source field, 0 selects the destination field |
| done | output | 1 | One-cycle pulse: result outputs valid |
| is_reg | output | 1 | Operand is a register (mode 0) |
| operand | output | 16 | Operand value |
| eff_addr | output | 16 | Effective address, or the register number in mode 0 |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read byte address (even) |
| mem_rdy | input | 1 | Memory read data valid, completes the request |
| mem_rdata | input | 16 | Memory read data |
| rf_we | input | 1 | Register file write enable (use while idle) |
| rf_waddr | input | 3 | Register file write index |
| rf_wdata | input | 16 | Register file write data |
| rf_raddr | input | 3 | Register file read index |
| rf_rdata | output | 16 | Register file read data |

## Verification
In the indexed modes with register 7, two things happen on the same clock edge. The program counter steps past the extension word, and the indexed address is formed from that same program counter. A design that adds the stale value would be off by exactly 2. The sweep runs every mode with every register, including 7, from both specifier fields and under several memory latencies. Each result is compared with PC+2+X as computed by the bench, and the program counter is read back afterwards. A second start is also injected during every multi-cycle sequence, and the unchanged result and register values show that it was ignored.

// File: rtl/amseq_pkg.sv
`timescale 1ns/1ps
package amseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_PTR, ST_DAT} seq_state_t;

  localparam logic [2:0] M_REG  = 3'd0;
  localparam logic [2:0] M_DEF  = 3'd1;
  localparam logic [2:0] M_INC  = 3'd2;
  localparam logic [2:0] M_INCD = 3'd3;
  localparam logic [2:0] M_DEC  = 3'd4;
  localparam logic [2:0] M_DECD = 3'd5;
  localparam logic [2:0] M_IDX  = 3'd6;
  localparam logic [2:0] M_IDXD = 3'd7;
endpackage

// File: rtl/amseq_regfile.sv
`timescale 1ns/1ps
module amseq_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [RW-1:0] ra1,
  output logic [DW-1:0] rd1,
  input  logic [RW-1:0] ra2,
  output logic [DW-1:0] rd2
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];
endmodule

// File: rtl/amseq_ctrl.sv
`timescale 1ns/1ps
module amseq_ctrl
  import amseq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int PC_IDX = 7,
  parameter int STEP   = 2,
  localparam int SPW   = 3 + RW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [SPW-1:0] spec,
  output logic           done,
  output logic           is_reg,
  output logic [DW-1:0]  operand,
  output logic [DW-1:0]  eff_addr,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic           mem_rdy,
  input  logic [DW-1:0]  mem_rdata,
  output logic [RW-1:0]  rd_sel,
  input  logic [DW-1:0]  rd_data,
  input  logic [DW-1:0]  pc_data,
  output logic           wr_en,
  output logic [RW-1:0]  wr_idx,
  output logic [DW-1:0]  wr_data
);
  localparam logic [DW-1:0] STEPV = DW'(STEP);
  localparam logic [RW-1:0] PCI   = RW'(PC_IDX);

  seq_state_t    state;
  logic [2:0]    mode_q;
  logic [RW-1:0] reg_q;
  logic [DW-1:0] addr_q;
  logic          req_q, done_q, isreg_q;
  logic [DW-1:0] val_q, ea_q;

  logic [2:0]    spec_mode;
  logic [RW-1:0] spec_reg;
  logic [DW-1:0] pc_next, idx_base;

  assign spec_mode = spec[SPW-1:RW];
  assign spec_reg  = spec[RW-1:0];
  assign pc_next   = pc_data + STEPV;
  // the PC-relative base is the counter already past the extension word
  assign idx_base  = (reg_q == PCI) ? pc_next : rd_data;

  always_comb begin
    rd_sel = (state == ST_IDLE) ? spec_reg : reg_q;
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = spec_reg;
    wr_data = rd_data + STEPV;
    if (state == ST_IDLE && start) begin
      if (spec_mode == M_INC || spec_mode == M_INCD) begin
        wr_en = 1'b1;
      end else if (spec_mode == M_DEC || spec_mode == M_DECD) begin
        wr_en   = 1'b1;
        wr_data = rd_data - STEPV;
      end
    end else if (state == ST_EXT && mem_rdy) begin
      wr_en   = 1'b1;
      wr_idx  = PCI;
      wr_data = pc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= '0;
      reg_q   <= '0;
      addr_q  <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      isreg_q <= 1'b0;
      val_q   <= '0;
      ea_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= spec_mode;
            reg_q  <= spec_reg;
            case (spec_mode)
              M_REG: begin
                val_q   <= rd_data;
                ea_q    <= DW'(spec_reg);
                isreg_q <= 1'b1;
                done_q  <= 1'b1;
              end
              M_DEF, M_INC: begin
                addr_q <= rd_data;
                req_q  <= 1'b1;
                state  <= ST_DAT;
              end
              M_INCD: begin
                addr_q <= rd_data;
                req_q  <= 1'b1;
                state  <= ST_PTR;
              end
              M_DEC: begin
                addr_q <= rd_data - STEPV;
                req_q  <= 1'b1;
                state  <= ST_DAT;
              end
              M_DECD: begin
                addr_q <= rd_data - STEPV;
                req_q  <= 1'b1;
                state  <= ST_PTR;
              end
              default: begin
                addr_q <= pc_data;
                req_q  <= 1'b1;
                state  <= ST_EXT;
              end
            endcase
          end
        end
        ST_EXT: begin
          if (mem_rdy) begin
            addr_q <= mem_rdata + idx_base;
            state  <= (mode_q == M_IDX) ? ST_DAT : ST_PTR;
          end
        end
        ST_PTR: begin
          if (mem_rdy) begin
            addr_q <= mem_rdata;
            state  <= ST_DAT;
          end
        end
        ST_DAT: begin
          if (mem_rdy) begin
            val_q   <= mem_rdata;
            ea_q    <= addr_q;
            isreg_q <= 1'b0;
            done_q  <= 1'b1;
            req_q   <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign is_reg   = isreg_q;
  assign operand  = val_q;
  assign eff_addr = ea_q;
  assign mem_req  = req_q;
  assign mem_addr = addr_q;

  a_r2_mode0_direct: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && spec_mode == M_REG) |=> (done && is_reg && !mem_req));

  a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_no_req_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXT && mem_rdy) |=> (pc_data == $past(pc_data) + STEPV));
endmodule

// File: rtl/amseq_top.sv
`timescale 1ns/1ps
module amseq_top #(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int STEP   = 2,
  localparam int RW    = $clog2(NREG),
  localparam int SPW   = 3 + RW,
  localparam int PC_IDX = NREG - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2*SPW-1:0] spec_pair,
  input  logic             src_sel,
  output logic             done,
  output logic             is_reg,
  output logic [DW-1:0]    operand,
  output logic [DW-1:0]    eff_addr,
  output logic             mem_req,
  output logic [DW-1:0]    mem_addr,
  input  logic             mem_rdy,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             rf_we,
  input  logic [RW-1:0]    rf_waddr,
  input  logic [DW-1:0]    rf_wdata,
  input  logic [RW-1:0]    rf_raddr,
  output logic [DW-1:0]    rf_rdata
);
  logic [SPW-1:0] spec;
  logic [RW-1:0]  rd_sel, wr_idx, w_addr;
  logic [DW-1:0]  rd_data, pc_data, wr_data, w_data;
  logic           wr_en, w_en;

  assign spec = src_sel ? spec_pair[2*SPW-1:SPW] : spec_pair[SPW-1:0];

  // sequencer updates take priority over the side port
  assign w_en   = wr_en | rf_we;
  assign w_addr = wr_en ? wr_idx  : rf_waddr;
  assign w_data = wr_en ? wr_data : rf_wdata;

  amseq_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .we    (w_en),
    .waddr (w_addr),
    .wdata (w_data),
    .ra0   (rd_sel),
    .rd0   (rd_data),
    .ra1   (RW'(PC_IDX)),
    .rd1   (pc_data),
    .ra2   (rf_raddr),
    .rd2   (rf_rdata)
  );

  amseq_ctrl #(.DW(DW), .RW(RW), .PC_IDX(PC_IDX), .STEP(STEP)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .spec      (spec),
    .done      (done),
    .is_reg    (is_reg),
    .operand   (operand),
    .eff_addr  (eff_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdy   (mem_rdy),
    .mem_rdata (mem_rdata),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .pc_data   (pc_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );
endmodule

// File: tb/amseq_top_tb.sv
`timescale 1ns/1ps
module amseq_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [11:0] spec_pair = '0;
  logic        src_sel = 1'b0;
  logic        done, is_reg, mem_req;
  logic [15:0] operand, eff_addr, mem_addr, rf_rdata;
  logic        mem_rdy = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_waddr = '0, rf_raddr = '0;
  logic [15:0] rf_wdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int lat = 0;
  int cnt = 0;
  int nacc = 0;

  always #2 clk = ~clk;

  amseq_top u_dut (
    .clk(clk), .rst(rst), .start(start), .spec_pair(spec_pair), .src_sel(src_sel),
    .done(done), .is_reg(is_reg), .operand(operand), .eff_addr(eff_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  function automatic logic [15:0] fmem(input logic [15:0] a);
    return a * 16'd7 + 16'h1234;
  endfunction

  // memory model: answers each request after lat idle cycles
  always @(negedge clk) begin
    if (rst || !mem_req) begin
      mem_rdy <= 1'b0;
      cnt <= 0;
    end else if (cnt >= lat) begin
      mem_rdy   <= 1'b1;
      mem_rdata <= fmem(mem_addr);
      cnt  <= 0;
      nacc <= nacc + 1;
    end else begin
      mem_rdy <= 1'b0;
      cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string mtag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input int m, input int r, input bit sel, input int l);
    logic [15:0] regs [8];
    logic [15:0] e_val, e_ea, e_r, e_pc, x, base, rv, pc;
    logic [5:0]  sp, alt;
    int          e_acc, n;
    lat = l;
    for (int i = 0; i < 8; i++) begin
      regs[i] = 16'h1000 + 16'(i) * 16'h0246 + 16'(m) * 16'h0010;
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = 3'(i); rf_wdata = regs[i];
    end
    @(negedge clk);
    rf_we = 1'b0;
    rf_raddr = 3'(r);
    #0.1;
    chk(rf_rdata == regs[r], "R13 side port readback", rf_rdata, regs[r]);
    rv = regs[r]; pc = regs[7];
    e_r = rv; e_pc = pc; e_acc = 0; e_val = 16'h0; e_ea = 16'h0;
    case (m)
      0: begin e_val = rv; e_ea = 16'(r); end
      1: begin e_ea = rv; e_acc = 1; end
      2: begin e_ea = rv; e_r = rv + 16'd2; e_acc = 1; end
      3: begin e_ea = fmem(rv); e_r = rv + 16'd2; e_acc = 2; end
      4: begin e_r = rv - 16'd2; e_ea = e_r; e_acc = 1; end
      5: begin e_r = rv - 16'd2; e_ea = fmem(e_r); e_acc = 2; end
      default: begin
        x = fmem(pc);
        e_pc = pc + 16'd2;
        base = (r == 7) ? e_pc : rv;
        e_ea = base + x;
        if (m == 7) e_ea = fmem(e_ea);
        e_acc = (m == 7) ? 3 : 2;
      end
    endcase
    if (m != 0) e_val = fmem(e_ea);
    if (r == 7) begin
      if (m == 2 || m == 3 || m >= 6) e_r = pc + 16'd2;
      e_pc = e_r;
    end
    sp  = {3'(m), 3'(r)};
    alt = ~sp;
    spec_pair = sel ? {sp, alt} : {alt, sp};
    src_sel = sel;
    nacc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!done) begin
      // R11: a second start during the sequence must be ignored
      spec_pair = sel ? {alt, sp} : {sp, alt};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      chk(1'b0, "R11 done never came", 16'h0, 16'h1);
      return;
    end
    chk(operand == e_val, {mtag(m), " R1 operand"}, operand, e_val);
    chk(eff_addr == e_ea, {mtag(m), " R1 eff_addr"}, eff_addr, e_ea);
    chk(is_reg == (m == 0), {mtag(m), " is_reg"}, 16'(is_reg), 16'(m == 0));
    chk(nacc == e_acc, {mtag(m), " R10 read count"}, 16'(nacc), 16'(e_acc));
    chk(!mem_req, "R11 no request at done", 16'(mem_req), 16'h0);
    @(negedge clk);
    chk(!done, "R11 done one cycle", 16'(done), 16'h0);
    rf_raddr = 3'(r);
    #0.1;
    chk(rf_rdata == e_r, {mtag(m), " register after"}, rf_rdata, e_r);
    rf_raddr = 3'd7;
    #0.1;
    chk(rf_rdata == e_pc, {mtag(m), " PC after"}, rf_rdata, e_pc);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!done,    "R12 done after reset",    16'(done),    16'h0);
    chk(!is_reg,  "R12 is_reg after reset",  16'(is_reg),  16'h0);
    chk(!mem_req, "R12 mem_req after reset", 16'(mem_req), 16'h0);
    for (int l = 0; l < 3; l++)
      for (int m = 0; m < 8; m++)
        for (int r = 0; r < 8; r++)
          for (int s = 0; s < 2; s++)
            run(m, r, s[0], l);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule